// File: doc/BRIEF.md
# Power-Bad and FET-Short Fault Detector

This block watches each channel of a hot-swap style power path and turns raw comparator bits and converter samples into clean fault and status flags. For every channel it receives a "feedback below threshold" comparator bit, a "gate enhanced" comparator bit and the gate-on command that the controller issues. A single shared data converter delivers current-sense codes tagged with a channel index and a valid strobe.

A power-bad condition counts only while the gate is enhanced. It must persist for a programmable number of clock cycles before it is reported; the default covers 2 µs at a 250 MHz clock. Once reported, it sets a live status flag and a sticky fault flag, and it asks the power-good output to pull low. A FET-short fault is raised when a converter sample taken while the channel's gate is commanded off reaches a programmable code. Sticky faults stay set until a per-channel clear.

Top module: `pwr_fault_mon`

## Requirements
- R1: While `rst_n` is low, all of `pbad_status`, `pbad_fault`, `short_fault` and `pg_drive_low` are 0, and the filter count of every channel restarts from zero.
- R2: A channel is qualified on a rising clock edge when `fb_low` and `gate_enh` are both 1. `pbad_status` becomes 1 after the (FILTER_CYCLES+1)-th consecutive qualified edge, and not before. Any unqualified edge restarts the count.
- R3: While `gate_enh` is 0, `fb_low` has no effect: `pbad_status` stays 0 and the filter count restarts.
- R4: After an edge on which a channel is unqualified, its `pbad_status` is 0.
- R5: `pbad_fault` is set on the same edge that sets `pbad_status`. It then holds at 1 until an edge on which `fault_clr` for that channel is 1 and no new power-bad is being reported. A new report wins over a clear.
- R6: `pg_drive_low` of a channel is 1 exactly while its `pbad_status` is 1. It is asserted in the same cycle as the status flag and released when the status flag clears.
- R7: `short_fault[i]` is set after an edge on which all of the following hold: `adc_valid` is 1, `adc_chan` equals i (channel index as an unsigned binary number), `gate_cmd[i]` is 0, and `adc_code`, read as unsigned, is greater than or equal to SHORT_CODE.
- R8: A sample does not set a short fault if any of these is true: `adc_valid` is 0, `adc_chan` names another channel, the gate is commanded on, or the code is below SHORT_CODE.
- R9: `short_fault` is sticky. An edge with `fault_clr[i]` at 1 clears it, unless a qualifying sample for that channel arrives on the same edge, in which case it stays set.
- R10: Channels are independent: inputs of one channel never change the flags of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fb_low | input | CHANNELS | Feedback below threshold, per channel |
| gate_enh | input | CHANNELS | Gate-to-source above enhancement threshold, per channel |
| gate_cmd | input | CHANNELS | Gate-on command, per channel |
| adc_valid | input | 1 | Converter sample strobe |
| adc_chan | input | SEL_W | Channel index of the current sample |
| adc_code | input | ADC_W | Unsigned current-sense code |
| fault_clr | input | CHANNELS | Clear of the sticky faults, per channel |
| pbad_status | output | CHANNELS | Live power-bad status |
| pbad_fault | output | CHANNELS | Sticky power-bad fault |
| short_fault | output | CHANNELS | Sticky FET-short fault |
| pg_drive_low | output | CHANNELS | Request to pull the power-good output low |

## Verification
The assertions assume that inputs are synchronous to `clk` and change only between edges. They also assume that `adc_chan` carries a value below CHANNELS whenever `adc_valid` is 1. The bench changes every input at the falling edge, so the rising edge always samples a settled value, and it draws the channel index only from the legal range. The feedback bit is held for long random stretches, so the filter actually matures, and the gate bit is sometimes dropped while feedback is low, so the masking path is exercised inside those stretches.

// File: rtl/pwr_fault_mon.sv
module pwr_fault_mon #(
  parameter int CHANNELS      = 2,
  parameter int FILTER_CYCLES = 500,
  parameter int ADC_W         = 12,
  parameter int SHORT_CODE    = 8,
  localparam int SEL_W        = (CHANNELS > 1) ? $clog2(CHANNELS) : 1,
  localparam int CNT_W        = $clog2(FILTER_CYCLES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CHANNELS-1:0] fb_low,
  input  logic [CHANNELS-1:0] gate_enh,
  input  logic [CHANNELS-1:0] gate_cmd,
  input  logic                adc_valid,
  input  logic [SEL_W-1:0]    adc_chan,
  input  logic [ADC_W-1:0]    adc_code,
  input  logic [CHANNELS-1:0] fault_clr,
  output logic [CHANNELS-1:0] pbad_status,
  output logic [CHANNELS-1:0] pbad_fault,
  output logic [CHANNELS-1:0] short_fault,
  output logic [CHANNELS-1:0] pg_drive_low
);

  localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(FILTER_CYCLES);
  localparam logic [ADC_W-1:0] SHORT_LIM = ADC_W'(SHORT_CODE);

  wire code_high = adc_code >= SHORT_LIM;

  for (genvar g = 0; g < CHANNELS; g++) begin : g_ch
    logic [CNT_W-1:0] cnt;
    logic             stat_q, pfault_q, sfault_q;

    wire qual = fb_low[g] & gate_enh[g];
    wire held = qual && (cnt == CNT_MAX);
    wire hit  = adc_valid && (adc_chan == SEL_W'(g)) && !gate_cmd[g] && code_high;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt      <= '0;
        stat_q   <= 1'b0;
        pfault_q <= 1'b0;
        sfault_q <= 1'b0;
      end else begin
        if (!qual)      cnt <= '0;
        else if (!held) cnt <= cnt + 1'b1;
        stat_q   <= held;
        pfault_q <= held | (pfault_q & ~fault_clr[g]);
        sfault_q <= hit  | (sfault_q & ~fault_clr[g]);
      end
    end

    assign pbad_status[g] = stat_q;
    assign pbad_fault[g]  = pfault_q;
    assign short_fault[g] = sfault_q;

    // R2: filter count never runs past its limit
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_MAX);

    // R3: status only after an edge with the gate enhanced
    p_status_needs_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_enh[g] |=> !pbad_status[g]);

    // R4: feedback recovery clears status on the next edge
    p_status_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !fb_low[g] |=> !pbad_status[g]);

    // R5: new status always carries the fault
    p_fault_with_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pbad_status[g]) |-> pbad_fault[g]);

    // R5: fault is sticky without a clear
    p_fault_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pbad_fault[g] && !fault_clr[g]) |=> pbad_fault[g]);

    // R7/R8: a short fault only rises after a qualifying gate-off sample
    p_short_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(short_fault[g]) |-> $past(adc_valid && !gate_cmd[g] && adc_chan == SEL_W'(g)));

    // R9: short fault is sticky without a clear
    p_short_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (short_fault[g] && !fault_clr[g]) |=> short_fault[g]);
  end

  assign pg_drive_low = pbad_status;

  // R6: power-good pull follows the live status
  p_pg_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pbad_status[0]) |-> pg_drive_low[0]);

endmodule

// File: tb/pwr_fault_mon_tb_top.sv
module pwr_fault_mon_tb_top;
  localparam int CH = 2, F = 8, AW = 10, LIM = 40, SW = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CH-1:0] fb_low = '0, gate_enh = '0, gate_cmd = '0, fault_clr = '0;
  logic adc_valid = 1'b0;
  logic [SW-1:0] adc_chan = '0;
  logic [AW-1:0] adc_code = '0;
  logic [CH-1:0] pbad_status, pbad_fault, short_fault, pg_drive_low;

  always #2 clk = ~clk;

  pwr_fault_mon #(.CHANNELS(CH), .FILTER_CYCLES(F), .ADC_W(AW), .SHORT_CODE(LIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .fb_low(fb_low), .gate_enh(gate_enh), .gate_cmd(gate_cmd),
    .adc_valid(adc_valid), .adc_chan(adc_chan), .adc_code(adc_code), .fault_clr(fault_clr),
    .pbad_status(pbad_status), .pbad_fault(pbad_fault), .short_fault(short_fault),
    .pg_drive_low(pg_drive_low));

  int checks = 0, failures = 0;
  bit done = 0;
  int m_cnt [CH];
  logic [CH-1:0] m_st, m_pf, m_sf, n_st, n_pf, n_sf;
  int n_cnt [CH];

  task automatic chk(input bit ok, input string req, input logic [CH-1:0] act, input logic [CH-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit sample_hit(input int i);
    return adc_valid && (int'(adc_chan) == i) && !gate_cmd[i] && (int'(adc_code) >= LIM);
  endfunction

  task automatic model_next();
    for (int i = 0; i < CH; i++) begin
      bit q, set;
      q = fb_low[i] & gate_enh[i];
      set = q && (m_cnt[i] == F);
      n_cnt[i] = !q ? 0 : (set ? m_cnt[i] : m_cnt[i] + 1);
      n_st[i] = set;
      n_pf[i] = set | (m_pf[i] & ~fault_clr[i]);
      n_sf[i] = sample_hit(i) | (m_sf[i] & ~fault_clr[i]);
    end
  endtask

  task automatic compare_all();
    chk(pbad_status == m_st, "R2/R3/R4 pbad_status", pbad_status, m_st);
    chk(pbad_fault == m_pf, "R5 pbad_fault", pbad_fault, m_pf);
    chk(short_fault == m_sf, "R7/R8/R9 short_fault", short_fault, m_sf);
    chk(pg_drive_low == m_st, "R6 pg_drive_low", pg_drive_low, m_st);
  endtask

  task automatic tick();
    model_next();
    @(negedge clk);
    for (int i = 0; i < CH; i++) m_cnt[i] = n_cnt[i];
    m_st = n_st; m_pf = n_pf; m_sf = n_sf;
    compare_all();
  endtask

  task automatic idle_inputs();
    fb_low = '0; gate_enh = '0; gate_cmd = '0; fault_clr = '0;
    adc_valid = 0; adc_chan = '0; adc_code = '0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7391));
    for (int i = 0; i < CH; i++) m_cnt[i] = 0;
    m_st = '0; m_pf = '0; m_sf = '0;
    repeat (3) @(negedge clk);
    fb_low = '1; gate_enh = '1; adc_valid = 1; adc_code = '1;
    @(negedge clk);
    chk(pbad_status == 0 && pbad_fault == 0 && short_fault == 0 && pg_drive_low == 0,
        "R1 reset outputs", pbad_status | pbad_fault | short_fault, '0);
    idle_inputs();
    rst_n = 1'b1;

    // R2: F qualified edges then a break: no status
    fb_low[0] = 1; gate_enh[0] = 1;
    repeat (F) tick();
    chk(pbad_status[0] == 0, "R2 not early", pbad_status, '0);
    fb_low[0] = 0; tick();
    fb_low[0] = 1;
    repeat (F) tick();
    chk(pbad_status[0] == 0, "R2 restart after break", pbad_status, '0);
    tick();
    chk(pbad_status[0] == 1, "R2 status after F+1 edges", pbad_status, 2'b01);
    chk(pg_drive_low[0] == 1, "R6 pg low with status", pg_drive_low, 2'b01);
    chk(pbad_fault[0] == 1, "R5 fault set", pbad_fault, 2'b01);
    chk(pbad_status[1] == 0 && pbad_fault[1] == 0, "R10 other channel quiet", pbad_status, 2'b01);
    fb_low[0] = 0; tick();
    chk(pbad_status[0] == 0 && pg_drive_low[0] == 0, "R4 status clears", pbad_status, '0);
    chk(pbad_fault[0] == 1, "R5 fault holds", pbad_fault, 2'b01);
    fault_clr[0] = 1; tick(); fault_clr[0] = 0;
    chk(pbad_fault[0] == 0, "R5 fault clears", pbad_fault, '0);

    // R3: gate not enhanced masks feedback
    fb_low = '1; gate_enh = '0;
    repeat (3*F) tick();
    chk(pbad_status == 0 && pbad_fault == 0, "R3 masked", pbad_status, '0);
    fb_low = '0;

    // R7/R8 short fault
    adc_valid = 1; adc_chan = 0; gate_cmd = '0; adc_code = AW'(LIM-1); tick();
    chk(short_fault == 0, "R8 below limit ignored", short_fault, '0);
    adc_chan = 1; adc_code = '1; gate_cmd[1] = 1; tick();
    chk(short_fault == 0, "R8 gate on ignored", short_fault, '0);
    adc_valid = 0; gate_cmd = '0; tick();
    chk(short_fault == 0, "R8 no strobe ignored", short_fault, '0);
    adc_valid = 1; adc_chan = 0; adc_code = AW'(LIM); tick();
    chk(short_fault == 2'b01, "R7 at limit sets", short_fault, 2'b01);
    fault_clr[0] = 1; tick();
    chk(short_fault == 2'b01, "R9 set wins over clear", short_fault, 2'b01);
    adc_valid = 0; tick(); fault_clr[0] = 0;
    chk(short_fault == 0, "R9 clear", short_fault, '0);

    // random phase
    idle_inputs();
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < CH; i++) begin
        if ($urandom_range(99) < 6)  fb_low[i]   = ~fb_low[i];
        if ($urandom_range(99) < 4)  gate_enh[i] = ~gate_enh[i];
        if ($urandom_range(99) < 10) gate_cmd[i] = ~gate_cmd[i];
        fault_clr[i] = ($urandom_range(99) < 3);
      end
      adc_valid = ($urandom_range(99) < 30);
      adc_chan  = SW'($urandom_range(CH-1));
      adc_code  = AW'($urandom_range(2*LIM));
      tick();
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule